// File: doc/BRIEF.md
# Instruction Immediate Extender

This block is a purely combinational stage in a 32-bit datapath. It takes a fetched instruction word and a six-bit format select, and produces the immediate operand that the ALU and the next-PC adder consume. The select is one-hot and is supplied by the decoder. Each select bit names one of six bit layouts: shift amount, I, S, B, U and J. The block gathers the scattered immediate fields of the chosen layout, puts them back in order, and extends the result to the datapath width.

The decoder chooses the format as follows. Immediate shifts use the shift-amount format, not the I format. Loads of any width, register-indirect jumps and the arithmetic/logic immediates use the I format. Stores use S, conditional branches use B, the upper-immediate instructions use U, and the direct jump uses J. A select with no bit set, or with several bits set, yields an immediate of zero. A malformed decode therefore cannot merge two layouts into one operand.

Top module: `imm_extend`

## Requirements
- R1: When the select is 6'b100000 (shift amount), the output is instruction bits [24:20] zero-extended. Every bit above bit 4 is 0.
- R2: When the select is 6'b010000 (I format), the output is instruction bits [31:20] sign-extended from instruction bit 31.
- R3: When the select is 6'b001000 (S format), the output is {bits [31:25], bits [11:7]} sign-extended from instruction bit 31.
- R4: When the select is 6'b000100 (B format), the output is {bit 31, bit 7, bits [30:25], bits [11:8], 1'b0} sign-extended from instruction bit 31. Bit 0 is always 0.
- R5: When the select is 6'b000010 (U format), the output is instruction bits [31:12] placed in output bits [31:12], with output bits [11:0] equal to 0.
- R6: When the select is 6'b000001 (J format), the output is {bit 31, bits [19:12], bit 20, bits [30:21], 1'b0} sign-extended from instruction bit 31. Bit 0 is always 0.
- R7: A select of 6'b000000 gives an all-zero output for any instruction word.
- R8: A select with two or more bits set gives an all-zero output for any instruction word.
- R9: The output depends only on the present inputs. It settles within the same cycle as an input change and holds no state from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 32 | Instruction word that holds the immediate fields |
| fmt_sel | input | 6 | One-hot format select: [5] shift amount, [4] I, [3] S, [2] B, [1] U, [0] J |
| imm_out | output | XLEN | Reassembled and extended immediate |

## Verification
The block holds no state, so any fault in the field routing shows at the output in the same cycle as the input that exposes it. A swapped field or a misplaced bit in one layout appears only for instruction words whose bits differ in those positions. For that reason every format is driven with many random words, and with all-ones, all-zeros and lone sign-bit words. A wrong sign source or a wrong zero-extension shows as upper output bits that disagree with instruction bit 31. A fault in the one-hot qualification shows as a nonzero output for an empty select or a multi-bit select.

// File: rtl/imm_extend.sv
module imm_extend #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_word,
  input  logic [5:0]      fmt_sel,
  output logic [XLEN-1:0] imm_out
);
  localparam int IW   = 32;
  localparam int EXTN = XLEN - IW + 1;

  logic [IW-1:0] f_sh, f_i, f_s, f_b, f_u, f_j;
  logic [IW-1:0] pick;
  logic          sel_ok;

  assign f_sh = {{(IW-5){1'b0}}, instr_word[24:20]};
  assign f_i  = {{(IW-12){instr_word[31]}}, instr_word[31:20]};
  assign f_s  = {{(IW-12){instr_word[31]}}, instr_word[31:25], instr_word[11:7]};
  assign f_b  = {{(IW-13){instr_word[31]}}, instr_word[31], instr_word[7],
                 instr_word[30:25], instr_word[11:8], 1'b0};
  assign f_u  = {instr_word[31:12], 12'b0};
  assign f_j  = {{(IW-21){instr_word[31]}}, instr_word[31], instr_word[19:12],
                 instr_word[20], instr_word[30:21], 1'b0};

  assign sel_ok = (fmt_sel != 6'b0) && ((fmt_sel & (fmt_sel - 6'd1)) == 6'b0);

  assign pick = {IW{sel_ok}} & (
                  ({IW{fmt_sel[5]}} & f_sh) |
                  ({IW{fmt_sel[4]}} & f_i)  |
                  ({IW{fmt_sel[3]}} & f_s)  |
                  ({IW{fmt_sel[2]}} & f_b)  |
                  ({IW{fmt_sel[1]}} & f_u)  |
                  ({IW{fmt_sel[0]}} & f_j));

  assign imm_out = {{(EXTN-1){pick[IW-1]}}, pick};

  always_comb begin
    if (!$isunknown({instr_word, fmt_sel})) begin
      AST_SHAMT_HIGH_ZERO: assert (fmt_sel != 6'b100000 || imm_out[XLEN-1:5] == '0)
        else $error("shift amount leaked upper bits"); // R1
      AST_SIGN_FOLLOWS: assert (!(fmt_sel inside {6'b010000, 6'b001000, 6'b000100, 6'b000001})
                                || imm_out[XLEN-1] == instr_word[31])
        else $error("sign bit mismatch"); // R2
      AST_EVEN_TARGET: assert (!(fmt_sel inside {6'b000100, 6'b000001}) || !imm_out[0])
        else $error("branch or jump offset odd"); // R4
      AST_UPPER_LOW_ZERO: assert (fmt_sel != 6'b000010 || imm_out[11:0] == 12'b0)
        else $error("upper immediate low bits nonzero"); // R5
      AST_EMPTY_SEL_ZERO: assert (fmt_sel != 6'b0 || imm_out == '0)
        else $error("empty select nonzero"); // R7
      AST_MULTI_SEL_ZERO: assert ($countones(fmt_sel) < 2 || imm_out == '0)
        else $error("multi-bit select nonzero"); // R8
    end
  end
endmodule

// File: tb/tb_imm_extend.sv
module tb_imm_extend;
  logic        clk = 1'b0;
  logic [31:0] instr_word;
  logic [5:0]  fmt_sel;
  logic [31:0] imm_out;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  imm_extend #(.XLEN(32)) dut (
    .instr_word(instr_word),
    .fmt_sel(fmt_sel),
    .imm_out(imm_out)
  );

  function automatic logic [31:0] sext(input logic [31:0] v, input int top);
    logic [31:0] r = v;
    for (int k = top + 1; k < 32; k++) r[k] = v[top];
    return r;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] w, input logic [5:0] s);
    logic [31:0] r = '0;
    case (s)
      6'b100000: r[4:0] = w[24:20];
      6'b010000: begin r[11:0] = w[31:20]; r = sext(r, 11); end
      6'b001000: begin r[4:0] = w[11:7]; r[11:5] = w[31:25]; r = sext(r, 11); end
      6'b000100: begin
        r[4:1] = w[11:8]; r[10:5] = w[30:25]; r[11] = w[7]; r[12] = w[31];
        r = sext(r, 12);
      end
      6'b000010: r[31:12] = w[31:12];
      6'b000001: begin
        r[10:1] = w[30:21]; r[11] = w[20]; r[19:12] = w[19:12]; r[20] = w[31];
        r = sext(r, 20);
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic apply_check(input logic [31:0] w, input logic [5:0] s, input string tag);
    @(negedge clk);
    instr_word = w;
    fmt_sel    = s;
    #1;
    total++;
    if (imm_out !== model(w, s)) begin
      bad++;
      $display("FAIL %s word=%h sel=%b actual=%h expected=%h", tag, w, s, imm_out, model(w, s));
    end
  endtask

  task automatic run_format(input logic [5:0] s, input string tag);
    apply_check(32'h0000_0000, s, tag);
    apply_check(32'hFFFF_FFFF, s, tag);
    apply_check(32'h8000_0000, s, tag);
    apply_check(32'h7FFF_FFFF, s, tag);
    for (int n = 0; n < 60; n++) apply_check($urandom, s, tag);
  endtask

  task automatic t_idle;
    apply_check(32'hFFFF_FFFF, 6'b000000, "R7 initial");
    for (int n = 0; n < 20; n++) apply_check($urandom, 6'b000000, "R7");
  endtask

  task automatic t_multi;
    for (int a = 0; a < 6; a++)
      for (int b = a + 1; b < 6; b++)
        apply_check(32'hFFFF_FFFF, 6'(1 << a) | 6'(1 << b), "R8 pair");
    apply_check(32'hFFFF_FFFF, 6'b111111, "R8 all");
    apply_check(32'hA5A5_5A5A, 6'b110001, "R8 triple");
  endtask

  task automatic t_no_memory;
    apply_check(32'hFFFF_FFFF, 6'b010000, "R9 prime");
    apply_check(32'h0000_0000, 6'b010000, "R9 follow");
    apply_check(32'hFFFF_FFFF, 6'b000010, "R9 switch");
    apply_check(32'hFFFF_FFFF, 6'b000000, "R9 clear");
  endtask

  initial begin
    instr_word = '0;
    fmt_sel    = '0;
    void'($urandom(32'd7));
    t_idle();
    run_format(6'b100000, "R1 shamt");
    run_format(6'b010000, "R2 I");
    run_format(6'b001000, "R3 S");
    run_format(6'b000100, "R4 B");
    run_format(6'b000010, "R5 U");
    run_format(6'b000001, "R6 J");
    t_multi();
    t_no_memory();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule